// File: doc/BRIEF.md
# FFT Phase Sequencer

This block is the free-running controller of a 1024-point FFT engine. Its sole state is a frame counter with a fixed budget of cycles. It tells the rest of the engine whether the current cycle belongs to sample loading, butterfly computation or result unloading. No unit hands back a completion signal, so every phase boundary is a fixed cycle number inside a frame of 12425 cycles. At the end of a frame the sequencer starts the next one at once.

During computation the sequencer also paces the butterfly pipeline. Each butterfly pair gets a slot of four cycles. In that slot the memories are accessed in the order read, write, read, write, and a 2-bit slot phase marks which of the four accesses is current. A stage index reports which of the ten stages is active. The half-span `ns` that the address logic needs is reported as well. A single-cycle marker flags the last compute cycle. A host watching the phase code starts to supply samples one clock after it sees the code change to the load value.

Top module: `fft_phase_sequencer`

## Requirements
- R1: In the cycle that follows a clock edge with `rst_n` low, the sequencer is at frame cycle 0: phase code 2'b01, stage 0, slot phase 0, `ns` = 512, `calc_done` low.
- R2: The phase code is 2'b01 while loading, 2'b11 while computing and 2'b10 while unloading. The value 2'b00 never appears.
- R3: Loading covers frame cycles 0 to 1027, which is 1024 samples plus four cycles of pipeline fill. Computing begins at frame cycle 1028.
- R4: Unloading covers frame cycles 11394 to 12424. The following cycle is frame cycle 0 of a new frame, in the load phase.
- R5: During computing, the slot phase equals (c mod 4), where c is the number of cycles since computing began. Outside computing it is 0.
- R6: A stage lasts 1036 cycles: 256 four-cycle slots plus 12 cycles of drain. The stage index equals c / 1036 for c < 10360. It then holds at 9 for the final 6 flush cycles, and it is 0 outside computing.
- R7: `ns` equals 512 shifted right by the stage index, so it is always one-hot.
- R8: `calc_done` is high only in frame cycle 11393, the last compute cycle, and only for that one cycle.
- R9: Pulling `rst_n` low in the middle of a frame, including during computing, restarts the frame at cycle 0 with all pacing outputs cleared, as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_o | output | 2 | Phase code: 01 load, 11 compute, 10 unload |
| stage_o | output | 4 | Compute stage index, 0 to 9 |
| ns_o | output | 10 | Butterfly half-span for the current stage |
| slot_o | output | 2 | Position inside the four-cycle butterfly slot |
| calc_done | output | 1 | High in the last compute cycle |

## Verification
A wrong value in the frame counter shows at once as a phase boundary in the wrong cycle, or as a misplaced `calc_done`. The bench compares every output in every cycle of two whole frames, so such an error is seen in the first cycle where it appears. A stage counter that advances at the wrong point changes `ns_o` and `stage_o` at a known cycle, and it is caught within one stage length. A slot counter that is not cleared or that does not wrap shows on `slot_o` in the first compute cycle after reset or after a frame boundary.

// File: rtl/fft_seq_pkg.sv
// Shared definitions for the FFT phase sequencer.
// Assumes: phase codes are decoded by neighbouring units, so values are fixed.
package fft_seq_pkg;

    typedef enum logic [1:0] {
        PH_NONE  = 2'b00,
        PH_LOAD  = 2'b01,
        PH_EMIT  = 2'b10,
        PH_CALC  = 2'b11
    } phase_e;

endpackage

// File: rtl/seq_frame_timer.sv
// Frame timer: counts cycles in a fixed-length frame and decodes the phase.
// Assumes: LOAD_LEN + CALC_LEN < FRAME_LEN, and CW is wide enough for FRAME_LEN.
module seq_frame_timer
    import fft_seq_pkg::*;
#(
    parameter int LOAD_LEN  = 1028,
    parameter int CALC_LEN  = 10366,
    parameter int FRAME_LEN = 12425,
    parameter int CW        = $clog2(FRAME_LEN)
) (
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   calc_last
);

    localparam logic [CW-1:0] CALC_FIRST = CW'(LOAD_LEN);
    localparam logic [CW-1:0] EMIT_FIRST = CW'(LOAD_LEN + CALC_LEN);
    localparam logic [CW-1:0] FRAME_END  = CW'(FRAME_LEN - 1);

    logic [CW-1:0] cyc_q;

    // Advance the frame cycle and wrap at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cyc_q == FRAME_END) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Map the frame cycle onto the phase code.
    always_comb begin
        if (cyc_q < CALC_FIRST) begin
            phase = PH_LOAD;
        end else if (cyc_q < EMIT_FIRST) begin
            phase = PH_CALC;
        end else begin
            phase = PH_EMIT;
        end
    end

    // Flag the final compute cycle.
    assign calc_last = (cyc_q == EMIT_FIRST - 1'b1);

    p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_NONE);

    p_calc_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CALC) |=> (phase == PH_CALC || phase == PH_EMIT));

    p_load_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) |=> (phase == PH_LOAD || phase == PH_CALC));

    p_emit_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EMIT) |=> (phase == PH_EMIT || phase == PH_LOAD));

endmodule

// File: rtl/seq_stage_pacer.sv
// Stage pacer: during computing, runs the four-cycle slot phase, the stage
// cycle counter and the stage index, and derives the butterfly half-span.
// Assumes: calc_active is high for one contiguous run per frame, and
// calc_last is high in its final cycle.
module seq_stage_pacer #(
    parameter int STAGES    = 10,
    parameter int SLOT      = 4,
    parameter int STAGE_LEN = 1036,
    parameter int SW        = $clog2(STAGES),
    parameter int LW        = $clog2(SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              calc_active,
    input  logic              calc_last,
    output logic [LW-1:0]     slot,
    output logic [SW-1:0]     stage,
    output logic [STAGES-1:0] ns
);

    localparam int KW = $clog2(STAGE_LEN + 16);
    localparam logic [KW-1:0]     STAGE_END = KW'(STAGE_LEN - 1);
    localparam logic [SW-1:0]     LAST_STG  = SW'(STAGES - 1);
    localparam logic [LW-1:0]     SLOT_END  = LW'(SLOT - 1);
    localparam logic [STAGES-1:0] NS_TOP    = {1'b1, {(STAGES-1){1'b0}}};

    logic          clear;
    logic [KW-1:0] kcyc_q;

    assign clear = !rst_n || !calc_active || calc_last;

    // Step the slot phase through the read-write-read-write order.
    always_ff @(posedge clk) begin
        if (clear || slot == SLOT_END) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // Count cycles within a stage and advance the stage index, holding the last.
    always_ff @(posedge clk) begin
        if (clear) begin
            kcyc_q <= '0;
            stage  <= '0;
        end else if (kcyc_q == STAGE_END && stage != LAST_STG) begin
            kcyc_q <= '0;
            stage  <= stage + 1'b1;
        end else begin
            kcyc_q <= kcyc_q + 1'b1;
        end
    end

    // Half-span halves with each stage.
    assign ns = NS_TOP >> stage;

    p_slot_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_active && !calc_last && slot == SLOT_END) |=> slot == '0);

    p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_active && !calc_last && slot != SLOT_END) |=> slot == $past(slot) + 1'b1);

    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_active |-> (slot == '0 && stage == '0));

    p_stage_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_active && !calc_last) |=>
            (stage == $past(stage) || stage == $past(stage) + 1'b1));

    p_stage_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stage <= LAST_STG);

    p_ns_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ns) == 1);

endmodule

// File: rtl/fft_phase_sequencer.sv
// FFT phase sequencer: fixed-budget frame of load, compute and unload phases,
// with four-cycle butterfly slot pacing and stage reporting during compute.
// Assumes: SAMPLES is a power of two with log2(SAMPLES) == STAGES.
module fft_phase_sequencer
    import fft_seq_pkg::*;
#(
    parameter int SAMPLES     = 1024,
    parameter int STAGES      = 10,
    parameter int SLOT        = 4,
    parameter int LOAD_FILL   = 4,
    parameter int STAGE_DRAIN = 12,
    parameter int CALC_FLUSH  = 6,
    parameter int EMIT_FILL   = 7,
    parameter int STAGE_W     = $clog2(STAGES),
    parameter int SLOT_W      = $clog2(SLOT)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [1:0]         phase_o,
    output logic [STAGE_W-1:0] stage_o,
    output logic [STAGES-1:0]  ns_o,
    output logic [SLOT_W-1:0]  slot_o,
    output logic               calc_done
);

    localparam int PAIRS     = SAMPLES / 4;
    localparam int LOAD_LEN  = SAMPLES + LOAD_FILL;
    localparam int STAGE_LEN = PAIRS * SLOT + STAGE_DRAIN;
    localparam int CALC_LEN  = STAGES * STAGE_LEN + CALC_FLUSH;
    localparam int EMIT_LEN  = SAMPLES + EMIT_FILL;
    localparam int FRAME_LEN = LOAD_LEN + CALC_LEN + EMIT_LEN;

    phase_e phase;
    logic   calc_last;
    logic   calc_active;

    seq_frame_timer #(
        .LOAD_LEN  (LOAD_LEN),
        .CALC_LEN  (CALC_LEN),
        .FRAME_LEN (FRAME_LEN)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .calc_last (calc_last)
    );

    assign calc_active = (phase == PH_CALC);

    seq_stage_pacer #(
        .STAGES    (STAGES),
        .SLOT      (SLOT),
        .STAGE_LEN (STAGE_LEN),
        .SW        (STAGE_W),
        .LW        (SLOT_W)
    ) u_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .calc_active (calc_active),
        .calc_last   (calc_last),
        .slot        (slot_o),
        .stage       (stage_o),
        .ns          (ns_o)
    );

    assign phase_o   = phase;
    assign calc_done = calc_active && calc_last;

    p_done_then_emit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |=> phase_o == 2'b10);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |=> !calc_done);

    p_done_last_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |-> stage_o == STAGE_W'(STAGES - 1));

endmodule

// File: tb/test_fft_phase_sequencer.sv
// Directed bench for the FFT phase sequencer; expected values come from the
// frame cycle number alone.
module test_fft_phase_sequencer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LOAD_N  = 1028;
    localparam int CALC_N  = 10366;
    localparam int FRAME_N = 12425;
    localparam int STG_N   = 1036;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] phase_o;
    logic [3:0] stage_o;
    logic [9:0] ns_o;
    logic [1:0] slot_o;
    logic       calc_done;

    int total = 0;
    int fails = 0;
    int now_t = 0;

    fft_phase_sequencer i_fft_phase_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_o   (phase_o),
        .stage_o   (stage_o),
        .ns_o      (ns_o),
        .slot_o    (slot_o),
        .calc_done (calc_done)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s frame cycle %0d: actual=%0d expected=%0d", tag, now_t, act, exp);
        end
    endtask

    function automatic int exp_phase(input int t);
        if (t < LOAD_N) return 1;
        if (t < LOAD_N + CALC_N) return 3;
        return 2;
    endfunction

    function automatic int exp_stage(input int t);
        int c;
        if (t < LOAD_N || t >= LOAD_N + CALC_N) return 0;
        c = t - LOAD_N;
        if (c >= 10 * STG_N) return 9;
        return c / STG_N;
    endfunction

    function automatic int exp_slot(input int t);
        if (t < LOAD_N || t >= LOAD_N + CALC_N) return 0;
        return (t - LOAD_N) % 4;
    endfunction

    // Compare every output against the frame-cycle model.
    task automatic sample_all(input int t);
        now_t = t;
        if (t < LOAD_N)               chk("R3 phase", int'(phase_o), exp_phase(t));
        else if (t < LOAD_N + CALC_N) chk("R2 phase", int'(phase_o), exp_phase(t));
        else                          chk("R4 phase", int'(phase_o), exp_phase(t));
        chk("R5 slot", int'(slot_o), exp_slot(t));
        chk("R6 stage", int'(stage_o), exp_stage(t));
        chk("R7 ns", int'(ns_o), 512 >> exp_stage(t));
        chk("R8 calc_done", int'(calc_done), (t == LOAD_N + CALC_N - 1) ? 1 : 0);
    endtask

    // R1: reset state at frame cycle 0.
    task automatic t_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        now_t = 0;
        chk("R1 phase", int'(phase_o), 1);
        chk("R1 stage", int'(stage_o), 0);
        chk("R1 slot", int'(slot_o), 0);
        chk("R1 ns", int'(ns_o), 512);
        chk("R1 calc_done", int'(calc_done), 0);
    endtask

    // R2..R8: two complete frames including the wrap into the next frame.
    task automatic t_frames(input int n);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            sample_all(k % FRAME_N);
        end
    endtask

    // R9: reset during computing restarts the frame.
    task automatic t_mid_reset();
        for (int k = 0; k < 6001; k++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        now_t = 0;
        chk("R9 phase", int'(phase_o), 1);
        chk("R9 stage", int'(stage_o), 0);
        chk("R9 slot", int'(slot_o), 0);
        chk("R9 ns", int'(ns_o), 512);
        for (int k = 1; k <= 1200; k++) begin
            @(negedge clk);
            sample_all(k);
        end
    endtask

    initial begin
        t_reset();
        t_frames(2 * FRAME_N + 3);
        t_mid_reset();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule